// File: doc/BRIEF.md
# Host Mailbox Byte-FIFO Register Window

This block sits between a host bus and a small management controller. The host sees a 32-byte register window with three live words: an interrupt word, a data word and a status word. Each byte the host writes to the data word goes into a transmit FIFO, which the controller drains through a valid/ready byte port. Bytes the controller offers on its own valid/ready port collect in a receive FIFO, and each host read of the data word pops one of them. Both FIFOs are byte-wide and eight entries deep by default.

The status word shows four conditions: transmit FIFO empty, transmit FIFO not full, receive FIFO not empty, and a sticky receive-overflow flag. For each condition the interrupt word holds a request bit, latched when the condition rises, and an enable bit. One interrupt line carries the OR of every enabled request. Software clears request bits and the overflow flag by writing ones to them. A single write to the interrupt word can both clear requests and set the enables.

Top module: `mbox_regwin`

## Requirements
- R1: After a synchronous active-high reset, status reads 0x3 (transmit empty, transmit not full), the interrupt word reads 0, `irq` is low, `ctl_tx_valid` is low and `ctl_rx_ready` is high.
- R2: The word offsets are interrupt 0x0, data 0x4 and status 0x8. Every other word of the 32-byte window (0xC to 0x1C) reads zero, and writes to those words change nothing.
- R3: A host write to the data word pushes `host_wdata[15:8]` into the transmit FIFO and ignores the other bits. The controller receives the bytes in write order on `ctl_tx_data`, one per cycle in which `ctl_tx_valid` and `ctl_tx_ready` are both high.
- R4: A host data write while the transmit FIFO holds DEPTH bytes is dropped. Status bit 1 (transmit not full) is 0 while the FIFO is full, and bit 0 (transmit empty) is 1 only when the FIFO is empty.
- R5: A host read of the data word returns the oldest received byte in bits 15:8, with all other bits zero, and pops it. Status bit 2 is 1 while the receive FIFO holds at least one byte.
- R6: A host data read while the receive FIFO is empty returns 0 and leaves the FIFO empty. The next received byte is then read back normally.
- R7: While the receive FIFO is full, `ctl_rx_ready` is low. A byte offered in that state is dropped and sets status bit 3 (overflow), which stays set through later reads until it is cleared.
- R8: Writing a 1 to status bit 3 clears the overflow flag, and writing 0 leaves it. Writing back the value read from status clears every flag that was set. Bits 2:0 follow the FIFO levels and do not respond to writes.
- R9: Each interrupt request bit (bits 3:0, in status bit order) sets on the clock edge after its condition goes from 0 to 1, and stays set after the condition falls.
- R10: A write to the interrupt word clears each request bit written with 1 and loads bits 7:4 as the four enable bits, both in the same write. A new rising edge in the same cycle wins over the clear.
- R11: `irq` is high exactly when some request bit and its enable bit are both set.
- R12: A reset in the middle of operation empties both FIFOs and clears the overflow flag, the request bits and the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 5 | Byte address within the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid during the access cycle |
| ctl_tx_valid | output | 1 | Transmit FIFO has a byte for the controller |
| ctl_tx_ready | input | 1 | Controller accepts the transmit byte |
| ctl_tx_data | output | 8 | Oldest transmit byte |
| ctl_rx_valid | input | 1 | Controller offers a byte to the host |
| ctl_rx_ready | output | 1 | Receive FIFO has room |
| ctl_rx_data | input | 8 | Byte offered by the controller |
| irq | output | 1 | Interrupt line |

## Verification
The bench fills the transmit FIFO past capacity with the controller stalled. A design that accepted the extra writes would deliver more bytes than fit, or overwrite old ones, and the scoreboard would see the wrong byte stream. It overruns the receive FIFO and reads past empty: a wrong design would wrap its pointers, hand back stale bytes or lose the overflow flag. It also checks that request bits stay latched after their condition falls, that one write can clear a request while setting its enable, and that a set but disabled request keeps `irq` low. A design that tied requests to the live levels, or ignored the enables, would fail those checks.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NCOND = 4;

  typedef enum logic [2:0] {
    SEL_INTR = 3'd0,
    SEL_DATA = 3'd1,
    SEL_STAT = 3'd2
  } reg_sel_e;

  // condition bit positions, shared by status and request fields
  localparam int C_TXE  = 0;
  localparam int C_TXNF = 1;
  localparam int C_RXNE = 2;
  localparam int C_RXO  = 3;

  function automatic logic [31:0] pack_byte(input logic [7:0] b);
    return {16'h0, b, 8'h00};
  endfunction

  function automatic logic [7:0] unpack_byte(input logic [31:0] w);
    return w[15:8];
  endfunction

  function automatic logic any_pending(input logic [NCOND-1:0] req,
                                       input logic [NCOND-1:0] en);
    return |(req & en);
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  // named internal events
  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  assign full  = (count == FULLC);
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop)
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    count <= FULLC);
  assert_full_push_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop |=> count == $past(count));
  assert_empty_pop_safe_R6: assert property (@(posedge clk) disable iff (rst)
    pop && empty && !push |=> empty);
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int               N        = 4,
  parameter logic [N-1:0]     RST_COND = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cond,
  input  logic         wr_en,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] en_bits,
  output logic [N-1:0] req,
  output logic [N-1:0] en,
  output logic         irq
);
  import mbox_pkg::*;

  logic [N-1:0] cond_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr;

  assign rise = cond & ~cond_q;
  assign clr  = wr_en ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= RST_COND;
      req    <= '0;
      en     <= '0;
    end else begin
      cond_q <= cond;
      req    <= (req & ~clr) | rise;
      if (wr_en) en <= en_bits;
    end
  end

  assign irq = any_pending(req, en);

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_req_from_edge_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(req[i]) |-> $past(cond[i]) && !$past(cond_q[i]));
    assert_req_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      req[i] && !clr[i] |=> req[i]);
    assert_req_w1c_R10: assert property (@(posedge clk) disable iff (rst)
      clr[i] && !rise[i] |=> !req[i]);
    assert_irq_enabled_R11: assert property (@(posedge clk) disable iff (rst)
      req[i] && en[i] |-> irq);
  end
  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $countones(req & en) > 0);
endmodule

// File: rtl/mbox_regwin.sv
module mbox_regwin #(
  parameter int DEPTH = 8,
  parameter int AW    = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_en,
  input  logic        host_we,
  input  logic [4:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        ctl_tx_valid,
  input  logic        ctl_tx_ready,
  output logic [7:0]  ctl_tx_data,
  input  logic        ctl_rx_valid,
  output logic        ctl_rx_ready,
  input  logic [7:0]  ctl_rx_data,
  output logic        irq
);
  import mbox_pkg::*;

  localparam int SW = AW - 2;
  localparam logic [NCOND-1:0] IDLE_COND = NCOND'((1 << C_TXE) | (1 << C_TXNF));

  // address decode
  logic [SW-1:0] sel;
  logic          wr_intr, wr_data, wr_stat, rd_data;
  assign sel     = host_addr[AW-1:2];
  assign wr_intr = host_en && host_we  && (sel == SW'(SEL_INTR));
  assign wr_data = host_en && host_we  && (sel == SW'(SEL_DATA));
  assign wr_stat = host_en && host_we  && (sel == SW'(SEL_STAT));
  assign rd_data = host_en && !host_we && (sel == SW'(SEL_DATA));

  logic unused_bits;
  assign unused_bits = ^{host_wdata[31:16], host_wdata[7:4], host_addr[1:0]};

  // transmit path
  logic       tx_full, tx_empty, tx_pop;
  assign tx_pop       = ctl_tx_valid && ctl_tx_ready;
  assign ctl_tx_valid = !tx_empty;

  mbox_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(wr_data), .pop(tx_pop),
    .din(unpack_byte(host_wdata)), .dout(ctl_tx_data),
    .full(tx_full), .empty(tx_empty)
  );

  // receive path
  logic       rx_full, rx_empty, rx_drop;
  logic [7:0] rx_head;
  assign ctl_rx_ready = !rx_full;
  assign rx_drop      = ctl_rx_valid && rx_full;

  mbox_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(ctl_rx_valid), .pop(rd_data),
    .din(ctl_rx_data), .dout(rx_head),
    .full(rx_full), .empty(rx_empty)
  );

  // sticky overflow
  logic ovf_q, ovf_clr;
  assign ovf_clr = wr_stat && host_wdata[C_RXO];
  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else     ovf_q <= (ovf_q && !ovf_clr) || rx_drop;
  end

  logic [NCOND-1:0] cond;
  always_comb begin
    cond         = '0;
    cond[C_TXE]  = tx_empty;
    cond[C_TXNF] = !tx_full;
    cond[C_RXNE] = !rx_empty;
    cond[C_RXO]  = ovf_q;
  end

  logic [NCOND-1:0] req, en;
  mbox_irq #(.N(NCOND), .RST_COND(IDLE_COND)) u_irq (
    .clk(clk), .rst(rst), .cond(cond),
    .wr_en(wr_intr),
    .clr_bits(host_wdata[NCOND-1:0]),
    .en_bits(host_wdata[2*NCOND-1:NCOND]),
    .req(req), .en(en), .irq(irq)
  );

  // read mux
  always_comb begin
    host_rdata = '0;
    if (host_en && !host_we) begin
      case (sel)
        SW'(SEL_INTR): host_rdata = {{(32-2*NCOND){1'b0}}, en, req};
        SW'(SEL_DATA): host_rdata = rx_empty ? 32'h0 : pack_byte(rx_head);
        SW'(SEL_STAT): host_rdata = {{(32-NCOND){1'b0}}, cond};
        default:       host_rdata = '0;
      endcase
    end
  end

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rd_data && rx_empty |-> host_rdata == 32'h0);
  assert_drop_sets_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_rx_valid && !ctl_rx_ready |=> ovf_q);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !ovf_clr |=> ovf_q);
  assert_ovf_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_clr && !rx_drop |=> !ovf_q);
  assert_full_no_txvalid_gap_R4: assert property (@(posedge clk) disable iff (rst)
    wr_data && tx_full && !tx_pop |=> tx_full);
endmodule

// File: tb/mbox_regwin_tb.sv
module mbox_regwin_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        host_en = 0, host_we = 0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ctl_tx_valid, ctl_tx_ready = 0;
  logic [7:0]  ctl_tx_data;
  logic        ctl_rx_valid = 0, ctl_rx_ready;
  logic [7:0]  ctl_rx_data = '0;
  logic        irq;

  int checks = 0, errors = 0;
  byte unsigned tx_exp[$];
  byte unsigned rx_exp[$];
  logic [31:0] rd;

  localparam int DEPTH = 8;

  mbox_regwin u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic hwr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    if (a == 5'h04 && tx_exp.size() < DEPTH) tx_exp.push_back(d[15:8]);
    @(posedge clk); #1;
    host_en = 0; host_we = 0;
  endtask

  task automatic hrd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    host_en = 1; host_we = 0; host_addr = a;
    #4 d = host_rdata;
    @(posedge clk); #1;
    host_en = 0;
  endtask

  // read the data word and compare against the receive model
  task automatic rd_byte(input string tag);
    logic [31:0] exp;
    exp = (rx_exp.size() > 0) ? {16'h0, rx_exp.pop_front(), 8'h00} : 32'h0;
    hrd(5'h04, rd);
    chk_eq(tag, rd, exp);
  endtask

  task automatic cpush(input byte unsigned b);
    @(negedge clk); #1;
    ctl_rx_valid = 1; ctl_rx_data = b;
    if (rx_exp.size() < DEPTH) rx_exp.push_back(b);
    @(posedge clk); #1;
    ctl_rx_valid = 0;
  endtask

  // scoreboard monitor for the controller-side transmit stream (R3)
  initial begin
    forever begin
      @(negedge clk); #5;
      if (!rst && ctl_tx_valid && ctl_tx_ready) begin
        if (tx_exp.size() == 0)
          chk(0, "R3 unexpected tx byte", {24'h0, ctl_tx_data}, 32'h0);
        else
          chk_eq("R3 tx byte order", {24'h0, ctl_tx_data}, {24'h0, tx_exp.pop_front()});
      end
    end
  end

  initial begin
    cyc(200000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk); #1 rst = 0;
    // R1 reset state
    hrd(5'h08, rd); chk_eq("R1 status after reset", rd, 32'h3);
    hrd(5'h00, rd); chk_eq("R1 intr after reset", rd, 32'h0);
    #5;
    chk_eq("R1 irq low", {31'h0, irq}, 32'h0);
    chk_eq("R1 tx_valid low", {31'h0, ctl_tx_valid}, 32'h0);
    chk_eq("R1 rx_ready high", {31'h0, ctl_rx_ready}, 32'h1);

    // R2 unused words read zero, writes ignored
    hwr(5'h0C, 32'hFFFF_FFFF);
    hwr(5'h1C, 32'hFFFF_FFFF);
    for (int a = 3; a < 8; a++) begin
      hrd(5'(a * 4), rd); chk_eq("R2 unused word zero", rd, 32'h0);
    end
    hrd(5'h08, rd); chk_eq("R2 status unchanged by unused write", rd, 32'h3);
    hrd(5'h00, rd); chk_eq("R2 intr unchanged by unused write", rd, 32'h0);

    // R3 bytes from bits 15:8, in order
    hwr(5'h04, 32'hDEAD_11EF);
    hwr(5'h04, 32'h1234_2256);
    hwr(5'h04, 32'hFFFF_33FF);
    hrd(5'h08, rd); chk_eq("R3 status tx not empty", rd, 32'h2);
    ctl_tx_ready = 1;
    cyc(6);
    chk_eq("R3 scoreboard drained", tx_exp.size(), 0);
    ctl_tx_ready = 0;

    // R4 overfill transmit FIFO
    for (int i = 0; i < 10; i++) hwr(5'h04, {16'h0, 8'(8'h40 + i), 8'h0});
    hrd(5'h08, rd); chk_eq("R4 status tx full", rd, 32'h0);
    ctl_tx_ready = 1;
    cyc(12);
    chk_eq("R4 only DEPTH bytes delivered", tx_exp.size(), 0);
    ctl_tx_ready = 0;
    hrd(5'h08, rd); chk_eq("R4 status tx empty again", rd, 32'h3);
    hrd(5'h00, rd); chk_eq("R9 tx requests latched", rd, 32'h3);

    // R10 clear all requests and enable rx-not-empty in one write
    hwr(5'h00, 32'h4F);
    cyc(1);
    hrd(5'h00, rd); chk_eq("R10 clear and enable", rd, 32'h40);
    #5 chk_eq("R11 irq low no request", {31'h0, irq}, 32'h0);

    // R5/R9/R11 receive a byte
    cpush(8'hA5);
    cyc(1);
    hrd(5'h08, rd); chk_eq("R5 status rx not empty", rd, 32'h7);
    hrd(5'h00, rd); chk_eq("R9 rx request set", rd, 32'h44);
    #5 chk_eq("R11 irq high", {31'h0, irq}, 32'h1);
    rd_byte("R5 read byte A5");
    cyc(1);
    hrd(5'h00, rd); chk_eq("R9 request sticky after fall", rd, 32'h44);
    hwr(5'h00, 32'h44);
    cyc(1);
    hrd(5'h00, rd); chk_eq("R10 request cleared", rd, 32'h40);
    #5 chk_eq("R11 irq low after clear", {31'h0, irq}, 32'h0);

    // R11 disabled request does not drive irq
    hwr(5'h00, 32'h00);
    cpush(8'h5A);
    cyc(1);
    hrd(5'h00, rd); chk_eq("R11 request without enable", rd, 32'h04);
    #5 chk_eq("R11 irq masked", {31'h0, irq}, 32'h0);
    rd_byte("R5 read byte 5A");

    // R6 empty read
    rd_byte("R6 empty read zero");
    hrd(5'h08, rd); chk_eq("R6 status still empty", rd, 32'h3);
    cpush(8'h3C);
    rd_byte("R6 next byte after empty read");

    // R7 receive overflow
    for (int i = 0; i < DEPTH; i++) cpush(8'(8'h10 + i));
    #5 chk_eq("R7 rx_ready low when full", {31'h0, ctl_rx_ready}, 32'h0);
    cpush(8'h99);
    hrd(5'h08, rd); chk_eq("R7 overflow set", rd, 32'hF);
    cyc(1);
    hrd(5'h00, rd); chk_eq("R9 overflow request", rd, 32'h0C);
    for (int i = 0; i < DEPTH + 1; i++) rd_byte("R7 in-order bytes, dropped lost");
    hrd(5'h08, rd); chk_eq("R7 overflow sticky", rd, 32'hB);

    // R8 write-one-to-clear
    hwr(5'h08, 32'h7);
    hrd(5'h08, rd); chk_eq("R8 zero in bit3 keeps flag", rd, 32'hB);
    hrd(5'h08, rd);
    hwr(5'h08, rd);
    hrd(5'h08, rd); chk_eq("R8 write-back clears", rd, 32'h3);

    // R12 reset mid-operation
    cpush(8'h01); cpush(8'h02);
    hwr(5'h00, 32'hF0);
    hwr(5'h04, 32'h0000_7700);
    hwr(5'h04, 32'h0000_7800);
    @(negedge clk); #1 rst = 1;
    cyc(1);
    @(negedge clk); #1 rst = 0;
    tx_exp.delete(); rx_exp.delete();
    hrd(5'h08, rd); chk_eq("R12 status after reset", rd, 32'h3);
    hrd(5'h00, rd); chk_eq("R12 intr after reset", rd, 32'h0);
    #5;
    chk_eq("R12 irq low", {31'h0, irq}, 32'h0);
    chk_eq("R12 tx_valid low", {31'h0, ctl_tx_valid}, 32'h0);
    rd_byte("R12 rx empty after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule